// File: doc/BRIEF.md
# ALU Status Flag Generator

This unit sits next to an adder/subtractor and derives six condition flags for each operation: carry, parity, auxiliary carry, zero, sign and overflow. It receives the two operands, the operation code, the operand width and the result word that the arithmetic unit produced. From these inputs it drives a combinational flag vector. The carry and half-carry terms come from the unit's own narrow carry chains. Zero, sign, parity and overflow come from the supplied result.

The operand width can be 8, 16 or 32 bits. Bits above the selected width are masked away before any flag is formed. A registered copy of the flags is also kept. On a clock edge with the valid strobe high, only the bits selected by a write mask load the new values. This lets logic operations refresh zero, sign and parity while leaving the other stored flags as they were.

Top module: `status_flag_gen`

## Requirements
- R1: For addition (op_sel 0), CF is the carry out of the most significant bit of the selected width.
- R2: For subtraction (op_sel 1), CF is the borrow. It is 1 exactly when the width-masked opnd_a is unsigned-less-than the width-masked opnd_b, which is the inverted carry-out of a + ~b + 1.
- R3: For addition, OF is 1 when both operand sign bits are equal and the result sign bit differs from them. For subtraction, OF is 1 when the operand sign bits differ and the result sign bit differs from opnd_a's sign bit.
- R4: SF equals the result bit at position width-1.
- R5: ZF is 1 exactly when the result bits below the selected width are all zero. Result bits above the width have no effect.
- R6: PF is 1 when result_in[7:0] holds an even number of ones, and 0 when the count is odd, for every width.
- R7: AF is the carry out of bit 3 of a+b for addition, and the borrow out of bit 3 of a-b for subtraction.
- R8: For the logic codes (op_sel 2 or 3), CF, OF and AF are forced to 0.
- R9: The size_sel encoding is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. Operand bits above the selected width are ignored.
- R10: The flag vector uses bit 0 = CF, 1 = PF, 2 = AF, 3 = ZF, 4 = SF, 5 = OF. flags_q changes on a rising clock edge only when valid is 1, and then only in the bits where wr_mask is 1; those bits take flags_now.
- R11: An active-low asynchronous reset (rst_n) clears flags_q to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_sel | input | 2 | Operand width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| op_sel | input | 2 | Operation: 0 = add, 1 = subtract, 2 or 3 = logic |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result_in | input | 32 | Result word from the arithmetic unit |
| valid | input | 1 | Allows flags_q to load on this edge |
| wr_mask | input | 6 | Per-flag load enable, same bit order as the flags |
| flags_now | output | 6 | Combinational flags for the current inputs |
| flags_q | output | 6 | Registered flags |

## Verification
The assertions assume that result_in is consistent with the operands. When result_in is zero below the width, the sign bit must be clear, and the parity check assumes the low byte is well defined. The assertions do not constrain the stimulus, and every input is driven to a known value from time zero. The bench computes each result itself and passes it to the design. It then fills the bits above the selected width with random junk, so the masking is exercised while the in-width result stays consistent with the operands.

// File: rtl/flag_pkg.sv
package flag_pkg;

    localparam int FLAG_N = 6;
    localparam int NUM_SZ = 3;
    localparam int BASE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_SUB    = 2'd1,
        OP_LOGIC  = 2'd2,
        OP_LOGIC2 = 2'd3
    } op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic hcy;
        logic par;
        logic cry;
    } flags_t;

endpackage

// File: rtl/width_select.sv
module width_select
    import flag_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W + 1)
) (
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] r_in,
    output logic [DATA_W-1:0] a_m,
    output logic [DATA_W-1:0] b_m,
    output logic [DATA_W-1:0] r_m,
    output logic [DATA_W-1:0] w_mask,
    output logic [IDX_W-1:0]  w_bits,
    output logic              a_top,
    output logic              b_top,
    output logic              r_top
);

    logic [DATA_W-1:0] mask_tab [NUM_SZ];
    logic [IDX_W-1:0]  bits_tab [NUM_SZ];
    logic [1:0]        sz_idx;

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
        localparam int SW = BASE_W << g;
        assign mask_tab[g] = DATA_W'((64'd1 << SW) - 64'd1);
        assign bits_tab[g] = IDX_W'(SW);
    end

    always_comb begin
        sz_idx = (size_sel == SZ_WORD2) ? 2'd2 : size_sel;
        w_mask = mask_tab[sz_idx];
        w_bits = bits_tab[sz_idx];
        a_m    = a_in & w_mask;
        b_m    = b_in & w_mask;
        r_m    = r_in & w_mask;
        a_top  = a_in[w_bits - 1'b1];
        b_top  = b_in[w_bits - 1'b1];
        r_top  = r_in[w_bits - 1'b1];
    end

endmodule

// File: rtl/carry_unit.sv
module carry_unit
    import flag_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W + 1)
) (
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] a_m,
    input  logic [DATA_W-1:0] b_m,
    input  logic [DATA_W-1:0] w_mask,
    input  logic [IDX_W-1:0]  w_bits,
    input  logic              a_top,
    input  logic              b_top,
    input  logic              r_top,
    output logic              cry,
    output logic              hcy,
    output logic              ovf
);

    logic [DATA_W:0] add_ext;
    logic [DATA_W:0] sub_ext;
    logic [4:0]      nib_add;
    logic [4:0]      nib_sub;
    logic            is_sub;
    logic            is_arith;

    always_comb begin
        is_sub   = (op_sel == OP_SUB);
        is_arith = (op_sel == OP_ADD) || is_sub;
        add_ext  = {1'b0, a_m} + {1'b0, b_m};
        sub_ext  = {1'b0, a_m} + {1'b0, (~b_m) & w_mask} + {{DATA_W{1'b0}}, 1'b1};
        nib_add  = {1'b0, a_m[3:0]} + {1'b0, b_m[3:0]};
        nib_sub  = {1'b0, a_m[3:0]} + {1'b0, ~b_m[3:0]} + 5'd1;
        cry = 1'b0;
        hcy = 1'b0;
        ovf = 1'b0;
        if (is_arith) begin
            if (is_sub) begin
                cry = ~sub_ext[w_bits];
                hcy = ~nib_sub[4];
                ovf = (a_top != b_top) && (r_top != a_top);
            end else begin
                cry = add_ext[w_bits];
                hcy = nib_add[4];
                ovf = (a_top == b_top) && (r_top != a_top);
            end
        end
    end

endmodule

// File: rtl/result_flags.sv
module result_flags #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] r_m,
    input  logic              r_top,
    output logic              zro,
    output logic              sgn,
    output logic              par
);

    always_comb begin
        zro = (r_m == '0);
        sgn = r_top;
        par = ~(^r_m[7:0]);
    end

endmodule

// File: rtl/flag_register.sv
module flag_register
    import flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [FLAG_N-1:0] wr_mask,
    input  logic [FLAG_N-1:0] d,
    output logic [FLAG_N-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (valid) begin
            q <= (q & ~wr_mask) | (d & wr_mask);
        end
    end

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(q));

    // R10
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> ((q ^ $past(q)) & ~$past(wr_mask)) == '0);

    // R10
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (q & $past(wr_mask)) == ($past(d) & $past(wr_mask)));

endmodule

// File: rtl/status_flag_gen.sv
module status_flag_gen
    import flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        size_sel,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result_in,
    input  logic              valid,
    input  logic [5:0]        wr_mask,
    output logic [5:0]        flags_now,
    output logic [5:0]        flags_q
);

    localparam int IDX_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] a_m, b_m, r_m, w_mask;
    logic [IDX_W-1:0]  w_bits;
    logic              a_top, b_top, r_top;
    flags_t            fl;

    width_select #(.DATA_W(DATA_W)) u_width (
        .size_sel (size_sel),
        .a_in     (opnd_a),
        .b_in     (opnd_b),
        .r_in     (result_in),
        .a_m      (a_m),
        .b_m      (b_m),
        .r_m      (r_m),
        .w_mask   (w_mask),
        .w_bits   (w_bits),
        .a_top    (a_top),
        .b_top    (b_top),
        .r_top    (r_top)
    );

    carry_unit #(.DATA_W(DATA_W)) u_carry (
        .op_sel (op_sel),
        .a_m    (a_m),
        .b_m    (b_m),
        .w_mask (w_mask),
        .w_bits (w_bits),
        .a_top  (a_top),
        .b_top  (b_top),
        .r_top  (r_top),
        .cry    (fl.cry),
        .hcy    (fl.hcy),
        .ovf    (fl.ovf)
    );

    result_flags #(.DATA_W(DATA_W)) u_result (
        .r_m   (r_m),
        .r_top (r_top),
        .zro   (fl.zro),
        .sgn   (fl.sgn),
        .par   (fl.par)
    );

    assign flags_now = fl;

    flag_register u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (valid),
        .wr_mask (wr_mask),
        .d       (flags_now),
        .q       (flags_q)
    );

    // R8
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[1] |-> (flags_now[0] == 1'b0 && flags_now[2] == 1'b0 && flags_now[5] == 1'b0));

    // R4 R5
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_now[3] |-> !flags_now[4]);

    // R6
    parity_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_in[7:0] == 8'h00) |-> flags_now[1]);

endmodule

// File: tb/tb_status_flag_gen.sv
`timescale 1ns/1ps
module tb_status_flag_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic [1:0]  op_sel = 2'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result_in = '0;
    logic        valid = 1'b0;
    logic [5:0]  wr_mask = '0;
    logic [5:0]  flags_now;
    logic [5:0]  flags_q;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [5:0] f;
        string      tag;
    } exp_t;
    exp_t        sb_q[$];
    logic [5:0]  exp_reg = '0;

    always #4 clk = ~clk;

    status_flag_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_sel  (size_sel),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result_in (result_in),
        .valid     (valid),
        .wr_mask   (wr_mask),
        .flags_now (flags_now),
        .flags_q   (flags_q)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [1:0] op, input logic [1:0] sz,
                                  output logic [31:0] r, output logic [5:0] f);
        int          w;
        logic [63:0] m, aw, bw, s;
        logic        sa, sb, sr, cf, af, of;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m  = (64'd1 << w) - 64'd1;
        aw = {32'd0, a} & m;
        bw = {32'd0, b} & m;
        cf = 1'b0; af = 1'b0; of = 1'b0;
        if (op == 2'd0) begin
            s  = aw + bw;
            cf = s[w];
            af = ((aw & 64'hF) + (bw & 64'hF)) > 64'hF;
        end else if (op == 2'd1) begin
            s  = (aw - bw) & m;
            cf = aw < bw;
            af = (aw & 64'hF) < (bw & 64'hF);
        end else begin
            s  = aw ^ bw;
        end
        s  = s & m;
        r  = s[31:0];
        sa = aw[w-1]; sb = bw[w-1]; sr = s[w-1];
        if (op == 2'd0) of = (sa == sb) && (sr != sa);
        if (op == 2'd1) of = (sa != sb) && (sr != sa);
        f = {of, sr, (s == 64'd0), af, ~(^s[7:0]), cf};
    endfunction

    task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                        input logic [1:0] sz, input logic v, input logic [5:0] m,
                        input logic [31:0] junk, input string tag);
        logic [31:0] r, wm;
        logic [5:0]  f;
        exp_t        e;
        @(negedge clk);
        model(a, b, op, sz, r, f);
        wm = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        opnd_a    = a | (junk & ~wm);
        opnd_b    = b | (~junk & ~wm);
        op_sel    = op;
        size_sel  = sz;
        result_in = r | (junk & ~wm);
        valid     = v;
        wr_mask   = m;
        #1;
        check(tag, flags_now, f);
        if (v) exp_reg = (exp_reg & ~m) | (f & m);
        e.f   = exp_reg;
        e.tag = {tag, " R10 reg"};
        sb_q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, flags_q, e.f);
            end
        end
    end

    initial begin : watchdog
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        check("R11 reset", flags_q, 6'b000000);
        rst_n = 1'b1;
        // R1 carry out of 8-bit add, zero, half carry, even parity
        step(32'hFF, 32'h01, 2'd0, 2'd0, 1'b1, 6'h3F, 32'hA5A5_0000, "R1 add8 carry");
        // R3 signed overflow on add
        step(32'h7F, 32'h01, 2'd0, 2'd0, 1'b1, 6'h3F, 32'h1234_5600, "R3 add8 ovf");
        // R2 borrow on 16-bit subtract
        step(32'h0001, 32'h0002, 2'd1, 2'd1, 1'b1, 6'h3F, 32'hFFFF_0000, "R2 sub16 borrow");
        // R3 subtract overflow
        step(32'h8000, 32'h0001, 2'd1, 2'd1, 1'b1, 6'h3F, 32'h5555_0000, "R3 sub16 ovf");
        // R9 size code 3 is 32-bit
        step(32'hFFFF_FFFF, 32'h1, 2'd0, 2'd3, 1'b1, 6'h3F, 32'h0, "R9 add32 alt size");
        // R5 zero ignores upper junk at 16-bit width
        step(32'h1234, 32'hEDCC, 2'd0, 2'd1, 1'b1, 6'h3F, 32'hFFFF_FFFF, "R5 zero16 junk");
        // R7 borrow out of bit 3
        step(32'h10, 32'h01, 2'd1, 2'd0, 1'b1, 6'h3F, 32'h0, "R7 sub8 half borrow");
        // R4 sign at 32 bits
        step(32'h8000_0000, 32'h0, 2'd0, 2'd2, 1'b1, 6'h3F, 32'h0, "R4 sign32");
        // R6 odd parity low byte in 32-bit word
        step(32'h0000_0107, 32'h0, 2'd0, 2'd2, 1'b1, 6'h3F, 32'h0, "R6 parity odd");
        // R8 logic ops clear carry, overflow, half carry
        step(32'hFF, 32'h0F, 2'd2, 2'd0, 1'b1, 6'h3F, 32'h0, "R8 logic");
        step(32'h8F, 32'h0F, 2'd3, 2'd0, 1'b1, 6'h3F, 32'h0, "R8 logic alt");
        // R10 partial mask then idle strobe
        step(32'hFF, 32'h01, 2'd0, 2'd0, 1'b1, 6'b011010, 32'h0, "R10 partial mask");
        step(32'h7F, 32'h01, 2'd0, 2'd0, 1'b0, 6'h3F, 32'h0, "R10 valid low");
        step(32'h00, 32'h00, 2'd1, 2'd1, 1'b1, 6'b000000, 32'h0, "R10 empty mask");
        for (int i = 0; i < 300; i++) begin
            step($urandom, $urandom, 2'($urandom), 2'($urandom), 1'($urandom),
                 6'($urandom), $urandom, "R1 R2 R3 R4 R5 R6 R7 random");
        end
        rst_n = 1'b0;
        #1;
        exp_reg = '0;
        sb_q.delete();
        check("R11 async reset", flags_q, 6'b000000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule